// File: doc/BRIEF.md
# Wake-Cycling Serial ADC Host Controller

This block is the host end of a serial link to a 16-channel, 12-bit successive-approximation converter that is run in one of its automatic low-power modes. In those modes the converter drops into a low-power state each time chip select returns high after a conversion. It starts to power up again on the next chip-select falling edge. The first frame after a wake therefore cannot produce a valid sample.

For every accepted request, the controller runs two chip-select-low frames of 16 serial clocks each. The first is a wake frame. Its control word is all zeros, so the WRITE bit is clear and the converter's control register is left as it was. Whatever the converter returns during this frame is thrown away. The second frame starts only after a programmable wake interval, counted in system clocks from the wake frame's chip-select fall, has run out. It writes a full control word that selects the requested channel and reloads the requested low-power mode. The 16 bits read back during this second frame are split into a 4-bit channel tag and a 12-bit sample. Both are presented on a ready/valid result port. As a result, only every other conversion reaches the user.

The serial clock is divided down from the system clock and idles high. The controller changes its data output only when the serial clock rises or chip select falls. It samples the converter's data on each serial-clock falling edge, most significant bit first.

Top module: `adc_pwr_host`

## Requirements
- R1: While reset is high and in the first cycle after it, cs_n and sclk are 1, res_valid is 0 and req_ready is 1.
- R2: Each accepted request produces exactly two chip-select-low frames. Each frame contains exactly 16 sclk falling edges.
- R3: In the first (wake) frame of a request, the first 12 bits shifted out on mosi are all 0, so WRITE is 0.
- R4: The 16 bits on mosi in the second frame, MSB first, are: WRITE=1, SEQ=0, the 4-bit req_chan, PM1=0, PM0=req_mode (1 selects auto shutdown, 0 selects auto standby), SHADOW=0, WEAK=0, RANGE=RANGE_BIT, CODING=CODING_BIT, then four 0 bits.
- R5: The result is taken only from the second frame. The first 4 miso bits of that frame (MSB first) appear on res_chan and the last 12 bits appear on res_data. Data from the wake frame never appears.
- R6: The block gives exactly one result per request. res_valid, res_chan and res_data hold steady until res_ready is sampled high, and res_valid drops in the following cycle.
- R7: Between any two frames, cs_n stays high for at least 2*SCLK_HALF system clocks.
- R8: The chip-select fall of the second frame comes at least WAKE_CYC system clocks after the chip-select fall of the wake frame.
- R9: req_ready is 0 from the acceptance of a request until its result has been taken. A request presented during that time is ignored.
- R10: mosi changes only when sclk rises or cs_n falls. It is stable while sclk is low, and each bit is sampled by the converter on the sclk falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_chan | input | 4 | Channel to convert |
| req_mode | input | 1 | 1 = auto shutdown, 0 = auto standby |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Control word to the converter |
| miso | input | 1 | Channel tag and result from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumer ready |
| res_chan | output | 4 | Channel tag from the converter |
| res_data | output | 12 | 12-bit sample |

## Verification
The bench runs requests at the extreme channel numbers in both modes, followed by a series of random channel, mode and consumer-delay combinations. Bit-ordering, field-placement and mode-bit errors each change the captured second-frame word in a different way. Every frame gets its own random return word from the bench. A result taken from the wake frame, or one shifted by a bit, therefore does not match the word the bench expects. A directed case presents a different request while the controller is busy, which shows that the second request is ignored rather than queued. Random stall lengths on res_ready show whether the result port holds its value or moves on.

// File: rtl/adcph_pkg.sv
package adcph_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CTL_BITS   = 12;
  localparam int CHAN_BITS  = 4;
  localparam int DATA_BITS  = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_WAKE, ST_CONV, ST_OUT} ctl_st_t;
  typedef enum logic [1:0] {FR_IDLE, FR_RUN, FR_GAP} fr_st_t;

  // Control word: WRITE, SEQ, ADDR[3:0], PM1, PM0, SHADOW, WEAK, RANGE, CODING, pad x4
  function automatic logic [FRAME_BITS-1:0] build_ctl(
    input logic [CHAN_BITS-1:0] chan,
    input logic                 pm0,
    input logic                 range_b,
    input logic                 coding_b);
    logic [CTL_BITS-1:0] w;
    w = {1'b1, 1'b0, chan, 1'b0, pm0, 1'b0, 1'b0, range_b, coding_b};
    return {w, {(FRAME_BITS-CTL_BITS){1'b0}}};
  endfunction
endpackage

// File: rtl/adcph_wake_timer.sv
module adcph_wake_timer #(
  parameter int WAKE_CYC = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic expired
);
  localparam int WW = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC + 1);
  localparam logic [WW-1:0] LAST = WW'(WAKE_CYC - 1);

  logic [WW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= LAST;
    else if (restart)   cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LAST);

  // R8: a freshly restarted interval is never already over (when longer than one cycle)
  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (restart && WAKE_CYC > 1) |=> !expired);
endmodule

// File: rtl/adcph_frame.sv
module adcph_frame
  import adcph_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] tx_word,
  output logic                  idle,
  output logic                  done,
  output logic [FRAME_BITS-1:0] rx_word,
  output logic                  cs_n,
  output logic                  sclk,
  output logic                  mosi,
  input  logic                  miso
);
  localparam int HW   = (SCLK_HALF < 2) ? 1 : $clog2(SCLK_HALF);
  localparam int BW   = $clog2(FRAME_BITS + 1);
  localparam int GAPC = 2 * SCLK_HALF;
  localparam int GW   = $clog2(GAPC + 1);

  fr_st_t                st;
  logic [HW-1:0]         hcnt;
  logic [BW-1:0]         bcnt;
  logic [GW-1:0]         gcnt;
  logic [FRAME_BITS-1:0] sh_tx, sh_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= FR_IDLE; cs_n <= 1'b1; sclk <= 1'b1; mosi <= 1'b0;
      hcnt <= '0; bcnt <= '0; gcnt <= '0;
      sh_tx <= '0; sh_rx <= '0; rx_word <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        FR_IDLE: if (start) begin
          cs_n  <= 1'b0;
          mosi  <= tx_word[FRAME_BITS-1];
          sh_tx <= tx_word << 1;
          hcnt  <= '0;
          bcnt  <= '0;
          st    <= FR_RUN;
        end
        FR_RUN: begin
          if (hcnt == HW'(SCLK_HALF - 1)) begin
            hcnt <= '0;
            if (sclk) begin
              sclk  <= 1'b0;
              sh_rx <= {sh_rx[FRAME_BITS-2:0], miso};
              bcnt  <= bcnt + 1'b1;
            end else begin
              sclk <= 1'b1;
              if (bcnt == BW'(FRAME_BITS)) begin
                cs_n    <= 1'b1;
                rx_word <= sh_rx;
                done    <= 1'b1;
                gcnt    <= '0;
                st      <= FR_GAP;
              end else begin
                mosi  <= sh_tx[FRAME_BITS-1];
                sh_tx <= sh_tx << 1;
              end
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        FR_GAP: begin
          if (gcnt == GW'(GAPC - 1)) st <= FR_IDLE;
          else                       gcnt <= gcnt + 1'b1;
        end
        default: st <= FR_IDLE;
      endcase
    end
  end

  assign idle = (st == FR_IDLE);

  // Checker state, kept apart from the frame logic
  logic          cs_d, sclk_d;
  logic [BW:0]   chk_falls;
  logic [GW:0]   chk_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d <= 1'b1; sclk_d <= 1'b1; chk_falls <= '0; chk_hi <= (GW+1)'(GAPC + 1);
    end else begin
      cs_d   <= cs_n;
      sclk_d <= sclk;
      if (cs_d && !cs_n)                chk_falls <= '0;
      else if (sclk_d && !sclk && !cs_n) chk_falls <= chk_falls + 1'b1;
      if (!cs_n)                          chk_hi <= '0;
      else if (chk_hi != (GW+1)'(GAPC + 1)) chk_hi <= chk_hi + 1'b1;
    end
  end

  p_frame_len_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_d && cs_n) |-> (chk_falls == (BW+1)'(FRAME_BITS)));

  p_cs_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (cs_d && !cs_n) |-> (chk_hi >= (GW+1)'(GAPC)));

  p_mosi_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!sclk && $past(!sclk)) |-> $stable(mosi));
endmodule

// File: rtl/adc_pwr_host.sv
module adc_pwr_host
  import adcph_pkg::*;
#(
  parameter int       SCLK_HALF  = 2,
  parameter int       WAKE_CYC   = 125,
  parameter bit       RANGE_BIT  = 1'b0,
  parameter bit       CODING_BIT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [3:0]  req_chan,
  input  logic        req_mode,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [3:0]  res_chan,
  output logic [11:0] res_data
);
  localparam int SW = $clog2(WAKE_CYC + 2);

  ctl_st_t               st;
  logic [CHAN_BITS-1:0]  chan_q;
  logic                  mode_q;
  logic                  fr_start, fr_idle, fr_done, got_done, wake_rs, wake_exp;
  logic [FRAME_BITS-1:0] tx_q, fr_rx;

  adcph_frame #(.SCLK_HALF(SCLK_HALF)) u_frame (
    .clk(clk), .rst(rst), .start(fr_start), .tx_word(tx_q),
    .idle(fr_idle), .done(fr_done), .rx_word(fr_rx),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  adcph_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk(clk), .rst(rst), .restart(wake_rs), .expired(wake_exp));

  assign req_ready = (st == ST_IDLE) && fr_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; chan_q <= '0; mode_q <= 1'b0; tx_q <= '0;
      fr_start <= 1'b0; wake_rs <= 1'b0; got_done <= 1'b0;
      res_valid <= 1'b0; res_chan <= '0; res_data <= '0;
    end else begin
      fr_start <= 1'b0;
      wake_rs  <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid && req_ready) begin
          chan_q   <= req_chan;
          mode_q   <= req_mode;
          tx_q     <= '0;          // keep-state wake frame
          fr_start <= 1'b1;
          wake_rs  <= 1'b1;
          got_done <= 1'b0;
          st       <= ST_WAKE;
        end
        ST_WAKE: begin
          if (fr_done) got_done <= 1'b1;
          if (got_done && fr_idle && wake_exp) begin
            tx_q     <= build_ctl(chan_q, mode_q, RANGE_BIT, CODING_BIT);
            fr_start <= 1'b1;
            got_done <= 1'b0;
            st       <= ST_CONV;
          end
        end
        ST_CONV: if (fr_done) begin
          res_valid <= 1'b1;
          res_chan  <= fr_rx[FRAME_BITS-1 -: CHAN_BITS];
          res_data  <= fr_rx[DATA_BITS-1:0];
          st        <= ST_OUT;
        end
        ST_OUT: if (res_ready) begin
          res_valid <= 1'b0;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Checker: cycles since the latest chip-select fall
  logic          cs_d;
  logic [SW-1:0] chk_since;
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d <= 1'b1; chk_since <= '0;
    end else begin
      cs_d <= cs_n;
      if (cs_d && !cs_n)                  chk_since <= '0;
      else if (chk_since != SW'(WAKE_CYC)) chk_since <= chk_since + 1'b1;
    end
  end

  p_wake_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (cs_d && !cs_n && st == ST_CONV) |-> (chk_since >= SW'(WAKE_CYC)));

  p_res_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_chan) && $stable(res_data)));

  p_busy_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !req_ready);

  p_res_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ready) |=> !res_valid);
endmodule

// File: tb/tb_adc_pwr_host.sv
module tb_adc_pwr_host;
  localparam int HALF = 2;
  localparam int WAKE = 125;
  localparam bit RB   = 1'b0;
  localparam bit CB   = 1'b1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, req_valid, req_ready, req_mode, cs_n, sclk, mosi, res_valid, res_ready;
  logic miso = 1'b0;
  logic [3:0]  req_chan, res_chan;
  logic [11:0] res_data;

  adc_pwr_host #(.SCLK_HALF(HALF), .WAKE_CYC(WAKE), .RANGE_BIT(RB), .CODING_BIT(CB)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_mode(req_mode), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .miso(miso), .res_valid(res_valid), .res_ready(res_ready),
    .res_chan(res_chan), .res_data(res_data));

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] words [128];
  logic [15:0] mo_log [128];
  int falls_log [128], fall_cyc [128], gap_log [128];
  int nfr = 0, bitidx = 0, hi_cnt = 100, glitch = 0;
  logic cs_p = 1'b1, sclk_p = 1'b1, mosi_p = 1'b0;

  // Converter model and link monitor
  always @(negedge clk) begin
    if (!rst && nfr < 127) begin
      if (cs_p && !cs_n) begin
        gap_log[nfr] = hi_cnt; fall_cyc[nfr] = cyc; mo_log[nfr] = '0;
        falls_log[nfr] = 0; bitidx = 15; miso = words[nfr][15];
      end
      if (!cs_n && sclk_p && !sclk) begin
        mo_log[nfr] = {mo_log[nfr][14:0], mosi};
        falls_log[nfr] = falls_log[nfr] + 1;
      end
      if (!cs_n && !sclk_p && sclk && bitidx > 0) begin
        bitidx = bitidx - 1; miso = words[nfr][bitidx];
      end
      if (!cs_n && !sclk_p && !sclk && mosi !== mosi_p) glitch = glitch + 1;
      if (!cs_p && cs_n) nfr = nfr + 1;
      hi_cnt = cs_n ? hi_cnt + 1 : 0;
    end
    cs_p = cs_n; sclk_p = sclk; mosi_p = mosi;
  end

  function automatic logic [15:0] exp_ctl(input logic [3:0] ch, input logic md);
    return {1'b1, 1'b0, ch, 1'b0, md, 1'b0, 1'b0, RB, CB, 4'b0000};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_req(input logic [3:0] ch, input logic md, input int rdy_delay, input bit junk);
    int f0, t;
    logic [3:0]  hc;
    logic [11:0] hd;
    f0 = nfr;
    @(negedge clk);
    req_valid = 1'b1; req_chan = ch; req_mode = md;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 busy after accept", {31'd0, req_ready}, 32'd0);
    if (junk) begin
      req_valid = 1'b1; req_chan = ~ch; req_mode = ~md;
      repeat (30) @(negedge clk);
      req_valid = 1'b0;
    end
    t = 0;
    while (!res_valid && t < 3000) begin @(negedge clk); t++; end
    @(negedge clk);
    chk(res_valid, "R6 result appears", {31'd0, res_valid}, 32'd1);
    chk(nfr - f0 == 2, "R2 frames per request", nfr - f0, 2);
    chk(falls_log[f0] == 16 && falls_log[f0+1] == 16, "R2 sclk falls",
        {falls_log[f0][15:0], falls_log[f0+1][15:0]}, 32'h0010_0010);
    chk(mo_log[f0][15:4] == 12'h000, "R3 wake word", mo_log[f0], 32'd0);
    chk(mo_log[f0+1] == exp_ctl(ch, md), "R4 control word", mo_log[f0+1], exp_ctl(ch, md));
    chk({res_chan, res_data} == words[f0+1], "R5 result from valid frame",
        {res_chan, res_data}, words[f0+1]);
    chk(fall_cyc[f0+1] - fall_cyc[f0] >= WAKE, "R8 wake interval",
        fall_cyc[f0+1] - fall_cyc[f0], WAKE);
    chk(gap_log[f0] >= 2*HALF && gap_log[f0+1] >= 2*HALF, "R7 cs high gap",
        gap_log[f0+1], 2*HALF);
    hc = res_chan; hd = res_data;
    repeat (rdy_delay) @(negedge clk);
    chk(res_valid && res_chan == hc && res_data == hd, "R6 hold while stalled",
        {res_valid, res_chan, res_data}, {1'b1, hc, hd});
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid, "R6 valid drops after take", {31'd0, res_valid}, 32'd0);
    repeat (10) @(negedge clk);
    chk(!res_valid && nfr - f0 == 2 && req_ready, "R9 no extra request run",
        nfr - f0, 2);
  endtask

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) words[i] = 16'($urandom);
    rst = 1'b1; req_valid = 1'b0; req_chan = '0; req_mode = 1'b0; res_ready = 1'b0;
    repeat (5) @(negedge clk);
    chk(cs_n && sclk && !res_valid, "R1 reset outputs", {cs_n, sclk, res_valid}, 3'b110);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && cs_n && sclk, "R1 idle after reset", {req_ready, cs_n, sclk}, 3'b111);

    do_req(4'd0,  1'b0, 0, 1'b0);
    do_req(4'd15, 1'b1, 3, 1'b0);
    do_req(4'd9,  1'b1, 1, 1'b1);   // R9: request during busy is ignored
    for (int k = 0; k < 20; k++)
      do_req(4'($urandom), 1'($urandom), int'($urandom % 6), 1'b0);

    chk(glitch == 0, "R10 mosi stable while sclk low", glitch, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule